// File: doc/BRIEF.md
# Departure-Ordered Cell Reorder Buffer

This block sits after a bulk memory that hands back cells of one memory block in whatever order it happens to read them. Each cell comes with the absolute slot in which it must leave. The block puts every cell straight into the storage position that its departure slot selects. A free-running slot counter then walks those positions one per cycle, so cells go out in strict departure order with no sorting and no queue pointers.

Storage is split into two equal banks, each deep enough for one memory block's worth of departures (`SECT_CELLS * SLOT_CYCLES` cells). One bank is filled while the other drains, and the roles swap each time the slot counter crosses a bank boundary. A cell whose slot has no entry produces an idle cycle. A write that cannot be stored is dropped and flagged one cycle later: either its position already holds a live cell, or its slot lies outside the fill window ahead of the counter.

Top module: `drb_reorder`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, `out_valid`, `out_data` and `wr_err` read zero, `out_slot` reads all ones, and no cell is held.
- R2: An accepted cell with departure time T is kept at position T mod 2·DEPTH, where DEPTH = SECT_CELLS·SLOT_CYCLES. Bit log2(DEPTH) of T picks the bank and the lower bits pick the entry. The cell appears on `out_data` with `out_valid` high in the cycle in which `out_slot` equals T. An accepted write raises no `wr_err`.
- R3: Cells leave in ascending departure order, whatever order they arrived in.
- R4: A slot with no stored cell gives `out_valid` low and `out_data` zero.
- R5: Each cell is emitted exactly once. Its entry is freed on emission, so the same position 2·DEPTH slots later is idle unless it is written again.
- R6: A write to a position that still holds an unsent cell is dropped, `wr_err` is high in the next cycle, and the old cell is later emitted unchanged.
- R7: A write whose distance (wr_time − current slot) mod 2^TIME_W is zero or at least 2·DEPTH is dropped, and `wr_err` is high in the next cycle. This covers a late cell, a cell for the slot being drained now, and a cell beyond the window.
- R8: Two cells whose departure times differ by exactly DEPTH go to different banks. Both are accepted and both are emitted.
- R9: `out_slot` advances by one each cycle after reset and wraps from 2^TIME_W−1 to 0. Cells remain correctly placed across the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cycle is one departure slot |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | A cell is offered this cycle |
| wr_time | input | TIME_W | Absolute departure slot of the offered cell |
| wr_data | input | DATA_W | Cell payload |
| out_valid | output | 1 | A cell leaves in this slot |
| out_data | output | DATA_W | Leaving cell payload, zero when idle |
| out_slot | output | TIME_W | Slot number that the current output belongs to |
| wr_err | output | 1 | The write of the previous cycle was dropped |

## Verification
The bench targets the following cases:

- **Cells arriving in reverse order.** A design that emitted cells in arrival order would show the wrong payloads in slots 3 to 5.
- **A second write to a live position.** A design that let it overwrite would emit the newer payload in place of the original.
- **A write for the slot currently being drained.** A design that accepted it would lose it, or emit it a full 2·DEPTH slots late, since that entry is being read in the same cycle.
- **Writes that straddle a bank boundary, or land exactly one bank apart.** A design that picked the bank with the wrong bit would have the two cells collide and report a false error.
- **A long idle run past the counter wrap, followed by random traffic.** This exposes entries that are never freed, since a stale cell would reappear one full cycle of the two banks later. It also exposes window checks that break when the time counter wraps.

// File: rtl/drb_pkg.sv
package drb_pkg;

   // Outcome of one offered write
   typedef enum logic [1:0] {
      WR_IDLE     = 2'd0,
      WR_STORE    = 2'd1,
      WR_OCCUPIED = 2'd2,
      WR_RANGE    = 2'd3
   } wr_verdict_e;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/drb_slot_map.sv
// Splits the low bits of a departure time into bank select and entry index.
module drb_slot_map #(
   parameter int unsigned IDX_W = 4
) (
   input  logic [IDX_W:0]   slot_lo,
   output logic [IDX_W-1:0] idx,
   output logic             bank
);
   assign idx  = slot_lo[IDX_W-1:0];
   assign bank = slot_lo[IDX_W];
endmodule

// File: rtl/drb_slot_ctr.sv
// Free-running departure slot counter.
module drb_slot_ctr #(
   parameter int unsigned TIME_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic [TIME_W-1:0] now
);
   always_ff @(posedge clk) begin
      if (!rst_n) now <= '0;
      else        now <= now + 1'b1;
   end
endmodule

// File: rtl/drb_bank.sv
// One bank of cell storage: per-entry valid bits plus a payload array.
module drb_bank #(
   parameter int unsigned DEPTH  = 16,
   parameter int unsigned DATA_W = 16,
   localparam int unsigned IDX_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic              wr_occ,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data
);
   logic [DEPTH-1:0]  live_q;
   logic [DATA_W-1:0] cell_q [DEPTH];

   for (genvar e = 0; e < DEPTH; e++) begin : g_entry
      always_ff @(posedge clk) begin
         if (!rst_n)
            live_q[e] <= 1'b0;
         else if (wr_en && (wr_idx == IDX_W'(e)))
            live_q[e] <= 1'b1;
         else if (rd_en && (rd_idx == IDX_W'(e)))
            live_q[e] <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) cell_q[wr_idx] <= wr_data;
   end

   assign wr_occ   = live_q[wr_idx];
   assign rd_valid = live_q[rd_idx];
   assign rd_data  = cell_q[rd_idx];
endmodule

// File: rtl/drb_reorder.sv
module drb_reorder
   import drb_pkg::*;
#(
   parameter int unsigned SECT_CELLS  = 4,
   parameter int unsigned SLOT_CYCLES = 4,
   parameter int unsigned DATA_W      = 16,
   parameter int unsigned TIME_W      = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_valid,
   input  logic [TIME_W-1:0] wr_time,
   input  logic [DATA_W-1:0] wr_data,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data,
   output logic [TIME_W-1:0] out_slot,
   output logic              wr_err
);
   localparam int unsigned DEPTH  = SECT_CELLS * SLOT_CYCLES;
   localparam int unsigned IDX_W  = $clog2(DEPTH);
   localparam int unsigned WINDOW = 2 * DEPTH;

   // Elaboration-time configuration checks
   if (!is_pow2(DEPTH)) begin : g_bad_depth
      $error("drb_reorder: SECT_CELLS*SLOT_CYCLES must be a power of two");
   end
   if (TIME_W <= IDX_W + 1) begin : g_bad_time
      $error("drb_reorder: TIME_W must exceed log2(2*DEPTH)");
   end
   if (DATA_W == 0) begin : g_bad_data
      $error("drb_reorder: DATA_W must be nonzero");
   end

   logic [TIME_W-1:0] now;
   logic [IDX_W-1:0]  w_idx, r_idx;
   logic              w_bank, r_bank;
   logic [TIME_W-1:0] ahead;
   logic              in_window, hit_occ;
   wr_verdict_e       verdict;

   logic              bank_occ   [2];
   logic              bank_rval  [2];
   logic [DATA_W-1:0] bank_rdata [2];

   drb_slot_ctr #(.TIME_W(TIME_W)) ctr_i (
      .clk   (clk),
      .rst_n (rst_n),
      .now   (now)
   );

   drb_slot_map #(.IDX_W(IDX_W)) wmap_i (
      .slot_lo (wr_time[IDX_W:0]),
      .idx     (w_idx),
      .bank    (w_bank)
   );

   drb_slot_map #(.IDX_W(IDX_W)) rmap_i (
      .slot_lo (now[IDX_W:0]),
      .idx     (r_idx),
      .bank    (r_bank)
   );

   // Distance ahead of the slot being drained; zero or beyond the window is refused
   assign ahead     = wr_time - now;
   assign in_window = (ahead != '0) && (ahead < TIME_W'(WINDOW));
   assign hit_occ   = bank_occ[w_bank];

   always_comb begin
      if (!wr_valid)       verdict = WR_IDLE;
      else if (!in_window) verdict = WR_RANGE;
      else if (hit_occ)    verdict = WR_OCCUPIED;
      else                 verdict = WR_STORE;
   end

   for (genvar bk = 0; bk < 2; bk++) begin : g_bank
      drb_bank #(.DEPTH(DEPTH), .DATA_W(DATA_W)) bank_i (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_en    ((verdict == WR_STORE) && (w_bank == 1'(bk))),
         .wr_idx   (w_idx),
         .wr_data  (wr_data),
         .rd_en    (r_bank == 1'(bk)),
         .rd_idx   (r_idx),
         .wr_occ   (bank_occ[bk]),
         .rd_valid (bank_rval[bk]),
         .rd_data  (bank_rdata[bk])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
         out_slot  <= '1;
         wr_err    <= 1'b0;
      end else begin
         out_valid <= bank_rval[r_bank];
         out_data  <= bank_rval[r_bank] ? bank_rdata[r_bank] : '0;
         out_slot  <= now;
         wr_err    <= (verdict == WR_OCCUPIED) || (verdict == WR_RANGE);
      end
   end
endmodule

// File: rtl/drb_reorder_chk.sv
module drb_reorder_chk #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned TIME_W = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_valid,
   input logic              in_window,
   input logic              hit_occ,
   input logic              out_valid,
   input logic [DATA_W-1:0] out_data,
   input logic [TIME_W-1:0] out_slot,
   input logic              wr_err
);
   logic armed_q;
   always_ff @(posedge clk) begin
      if (!rst_n) armed_q <= 1'b0;
      else        armed_q <= 1'b1;
   end

   // R4
   idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> (out_data == '0));

   // R6
   occ_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && in_window && hit_occ) |=> wr_err);

   // R7
   range_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && !in_window) |=> wr_err);

   // R2
   clean_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && in_window && !hit_occ) |=> !wr_err);

   // R6
   err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed_q && wr_err) |-> $past(wr_valid));

   // R9
   slot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      armed_q |-> (out_slot == $past(out_slot) + 1'b1));
endmodule

bind drb_reorder drb_reorder_chk #(.DATA_W(DATA_W), .TIME_W(TIME_W)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_valid  (wr_valid),
   .in_window (in_window),
   .hit_occ   (hit_occ),
   .out_valid (out_valid),
   .out_data  (out_data),
   .out_slot  (out_slot),
   .wr_err    (wr_err)
);

// File: tb/drb_reorder_tb_top.sv
`timescale 1ns/1ps
module drb_reorder_tb_top;
   localparam int unsigned NC = 4;
   localparam int unsigned NB = 4;
   localparam int unsigned DW = 16;
   localparam int unsigned TW = 12;
   localparam int unsigned D  = NC * NB;
   localparam int unsigned W2 = 2 * D;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_valid = 1'b0;
   logic [TW-1:0] wr_time = '0;
   logic [DW-1:0] wr_data = '0;
   logic          out_valid;
   logic [DW-1:0] out_data;
   logic [TW-1:0] out_slot;
   logic          wr_err;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   // Bench model of stored cells, indexed by departure time mod 2*D
   bit            ref_v [W2];
   logic [DW-1:0] ref_d [W2];
   logic [TW-1:0] mc;
   int            emitted;

   always #2 clk = ~clk;

   drb_reorder #(.SECT_CELLS(NC), .SLOT_CYCLES(NB), .DATA_W(DW), .TIME_W(TW)) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_time(wr_time), .wr_data(wr_data),
      .out_valid(out_valid), .out_data(out_data), .out_slot(out_slot), .wr_err(wr_err)
   );

   function automatic bit exp_refused(input logic [TW-1:0] t, input logic [TW-1:0] now,
                                      input bit occ);
      logic [TW-1:0] dl;
      dl = t - now;
      return (dl == '0) || (dl >= TW'(W2)) || occ;
   endfunction

   task automatic chk(input string tag, input string what, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   // One slot: offer an optional write, predict, then compare after the edge
   task automatic step(input string tag, input bit v, input logic [TW-1:0] t,
                       input logic [DW-1:0] d);
      int ri, wi;
      bit ev, ee;
      logic [DW-1:0] ed;
      ri = int'(mc % TW'(W2));
      wi = int'(t % TW'(W2));
      ev = ref_v[ri];
      ed = ev ? ref_d[ri] : '0;
      ee = v && exp_refused(t, mc, ref_v[wi]);
      ref_v[ri] = 0;
      if (v && !ee) begin
         ref_v[wi] = 1;
         ref_d[wi] = d;
      end
      wr_valid = v; wr_time = t; wr_data = d;
      @(posedge clk);
      @(negedge clk);
      wr_valid = 1'b0;
      chk(tag, "out_valid", longint'(out_valid), longint'(ev));
      chk(tag, "out_data", longint'(out_data), longint'(ed));
      chk(tag, "out_slot", longint'(out_slot), longint'(mc));
      chk(tag, "wr_err", longint'(wr_err), longint'(ee));
      if (ev) emitted++;
      mc = mc + 1'b1;
   endtask

   task automatic idle(input string tag, input int n);
      for (int i = 0; i < n; i++) step(tag, 1'b0, '0, '0);
   endtask

   initial begin
      int acc;
      for (int i = 0; i < W2; i++) begin ref_v[i] = 0; ref_d[i] = '0; end
      mc = '0;
      emitted = 0;
      void'($urandom(32'd20240607));
      rst_n = 1'b0;
      repeat (4) @(posedge clk);
      @(negedge clk);
      // R1 reset state
      chk("R1", "out_valid", longint'(out_valid), 0);
      chk("R1", "out_data", longint'(out_data), 0);
      chk("R1", "wr_err", longint'(wr_err), 0);
      chk("R1", "out_slot", longint'(out_slot), longint'(12'hFFF));
      rst_n = 1'b1;

      // R3: arrivals 5,3,4 must leave as 3,4,5
      step("R3", 1'b1, 12'd5, 16'hA005);
      step("R3", 1'b1, 12'd3, 16'hA003);
      step("R3", 1'b1, 12'd4, 16'hA004);
      idle("R3", 4);
      // R4 idle slots
      idle("R4", 5);

      // R6: second write to a live position is dropped, first survives
      step("R6", 1'b1, mc + 12'd10, 16'hB001);
      step("R6", 1'b1, mc + 12'd9, 16'hB002);
      idle("R6", 12);

      // R7: write for the slot being drained, a late one and one beyond the window
      step("R7", 1'b1, mc, 16'hC001);
      step("R7", 1'b1, mc - 12'd3, 16'hC002);
      step("R7", 1'b1, mc + 12'(W2), 16'hC003);
      step("R7", 1'b1, mc + 12'(W2 - 1), 16'hC004);
      idle("R7", W2);

      // R8: two cells one bank apart
      step("R8", 1'b1, mc + 12'd3, 16'hD001);
      step("R8", 1'b1, mc + 12'(D + 2), 16'hD002);
      idle("R8", D + 4);

      // R5: every entry freed after emission, nothing reappears one full turn later
      acc = emitted;
      idle("R5", W2 + 2);
      chk("R5", "no re-emission", longint'(emitted), longint'(acc));

      // R9: run through the counter wrap with a cell placed across it
      while (mc != 12'd4090) step("R9", 1'b0, '0, '0);
      step("R9", 1'b1, 12'd2, 16'hE002);
      step("R9", 1'b1, 12'd4094, 16'hE0FE);
      idle("R9", 12);

      // R2: constrained random traffic, mostly in window, some out
      for (int i = 0; i < 3000; i++) begin
         bit v;
         logic [TW-1:0] t;
         v = ($urandom % 4) != 0;
         if (($urandom % 8) == 0) t = TW'($urandom);
         else                     t = mc + TW'(1 + ($urandom % (W2 + 2)));
         step("R2", v, t, DW'($urandom));
      end
      idle("R2", W2 + 2);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule